// File: doc/BRIEF.md
# Dual-Port Byte Memory with Mailbox Interrupts

This block is a true dual-port memory of 2048 bytes, with a left port and a right port that share one clock. Either port may read or write any location in any cycle. A read is registered, so the byte comes out one cycle after the address, together with a valid bit.

The two highest locations also act as mailboxes, so the two agents on the ports can signal each other. When the right port writes location 0x7FE, the left interrupt rises. When the left port writes location 0x7FF, the right interrupt rises. Each receiver clears its own interrupt by reading its mailbox location. The byte written to a mailbox is still stored as ordinary data.

Each port has a hold input, driven by arbitration logic outside the block. While hold is active it suppresses that port's writes and mailbox signalling. A parameter can remove the mailbox behaviour. The top two locations are then plain memory and both interrupts stay low.

Top module: `dpram_mailbox`

## Requirements
- R1: A port writes `wdata` into the location at `addr` when its `cs` and `we` are both high and its `hold` is low. A port with `cs` and `oe` high returns that location's byte on `rdata`, with `rvalid` high, exactly one clock later.
- R2: If a port's `cs` or `oe` was low at an edge, then after that edge `rvalid` is 0 and `rdata` is 0.
- R3: When the mailbox function is on, a right-port write (`rt_cs`, `rt_we` high, `rt_hold` low) to address 0x7FE sets `lt_irq` high from the next cycle.
- R4: When the mailbox function is on, a left-port write (`lt_cs`, `lt_we` high, `lt_hold` low) to address 0x7FF sets `rt_irq` high from the next cycle.
- R5: The left port clears `lt_irq` by presenting address 0x7FE with `lt_cs` and `lt_oe` high, and the right port clears `rt_irq` the same way at 0x7FF. The level of `we` does not matter. A clear lands in the next cycle. If a set and a clear of the same flag happen in the same cycle, the set wins.
- R6: While a port's `hold` is high, its write leaves memory unchanged and does not set the opposite interrupt.
- R7: The bytes at 0x7FE and 0x7FF are stored and read back like those at any other address.
- R8: If both ports write the same location in the same cycle, the left port's byte is the one stored.
- R9: A read of a location that is written in the same cycle, by either port, returns the byte held before that write.
- R10: With parameter `MBOX_EN` = 0, `lt_irq` and `rt_irq` stay 0 under every stimulus, and 0x7FE and 0x7FF act as plain memory.
- R11: Synchronous reset (`rst` high) clears both interrupts, both `rvalid` outputs and both `rdata` outputs. Memory contents survive a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| lt_cs | input | 1 | Left port select |
| lt_we | input | 1 | Left port write enable |
| lt_oe | input | 1 | Left port read enable |
| lt_hold | input | 1 | Left port write inhibit from external arbitration |
| lt_addr | input | 11 | Left port address |
| lt_wdata | input | 8 | Left port write byte |
| lt_rdata | output | 8 | Left port read byte, 0 when not valid |
| lt_rvalid | output | 1 | Left port read byte is valid |
| lt_irq | output | 1 | Left interrupt, set by the right port's mailbox write |
| rt_cs | input | 1 | Right port select |
| rt_we | input | 1 | Right port write enable |
| rt_oe | input | 1 | Right port read enable |
| rt_hold | input | 1 | Right port write inhibit from external arbitration |
| rt_addr | input | 11 | Right port address |
| rt_wdata | input | 8 | Right port write byte |
| rt_rdata | output | 8 | Right port read byte, 0 when not valid |
| rt_rvalid | output | 1 | Right port read byte is valid |
| rt_irq | output | 1 | Right interrupt, set by the left port's mailbox write |

## Verification
A wrong interrupt flag shows at the ports in the cycle after the write or read that should have changed it. A flag that is set while hold is active, or a clear that beats a set in the same cycle, is therefore caught one clock later.

A corrupted memory byte stays hidden until some port reads that location. For this reason every random read targets a location whose contents the reference model knows. A mistake in write priority, hold gating or read-before-write ordering then appears on `rdata` one clock after the read that exposes it. A second instance with the mailbox disabled runs under the same stimulus, and any interrupt it raises is an error.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    // Control strobes of one port, width independent.
    typedef struct packed {
        logic cs;
        logic we;
        logic oe;
        logic hold;
    } dpm_ctl_t;

    // A write takes effect only when selected, enabled and not held.
    function automatic logic ctl_writes(dpm_ctl_t c);
        return c.cs & c.we & ~c.hold;
    endfunction

    // A read access (also the mailbox acknowledge) ignores the write enable.
    function automatic logic ctl_reads(dpm_ctl_t c);
        return c.cs & c.oe;
    endfunction

endpackage

// File: rtl/dpm_array.sv
module dpm_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] a_word,
    output logic [DATA_W-1:0] b_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Combinational look-up: the value before this edge's writes.
    assign a_word = mem_q[a_addr];
    assign b_word = mem_q[b_addr];

    // Port b is applied first so that port a wins a same-address collision.
    always_ff @(posedge clk) begin
        if (b_wr) mem_q[b_addr] <= b_wdata;
        if (a_wr) mem_q[a_addr] <= a_wdata;
    end

endmodule

// File: rtl/dpm_rdport.sv
module dpm_rdport #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        if (rd_en) begin
            rd_d.valid = 1'b1;
            rd_d.data  = word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_d;
    end

    assign rdata  = rd_q.data;
    assign rvalid = rd_q.valid;

endmodule

// File: rtl/dpm_mbox.sv
module dpm_mbox
    import dpm_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter bit MBOX_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  dpm_ctl_t          lt_ctl,
    input  logic [ADDR_W-1:0] lt_addr,
    input  dpm_ctl_t          rt_ctl,
    input  logic [ADDR_W-1:0] rt_addr,
    output logic              lt_irq,
    output logic              rt_irq
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] LT_BOX   = TOP_ADDR - 1'b1;
    localparam logic [ADDR_W-1:0] RT_BOX   = TOP_ADDR;

    typedef struct packed {
        logic lt_flag;
        logic rt_flag;
    } flags_t;

    flags_t fl_d, fl_q;
    logic   lt_set, lt_clr, rt_set, rt_clr;

    always_comb begin
        lt_set = MBOX_EN && ctl_writes(rt_ctl) && (rt_addr == LT_BOX);
        rt_set = MBOX_EN && ctl_writes(lt_ctl) && (lt_addr == RT_BOX);
        lt_clr = ctl_reads(lt_ctl) && (lt_addr == LT_BOX);
        rt_clr = ctl_reads(rt_ctl) && (rt_addr == RT_BOX);

        fl_d = fl_q;
        // Set dominates a same-cycle clear.
        if (lt_set)      fl_d.lt_flag = 1'b1;
        else if (lt_clr) fl_d.lt_flag = 1'b0;
        if (rt_set)      fl_d.rt_flag = 1'b1;
        else if (rt_clr) fl_d.rt_flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) fl_q <= '0;
        else     fl_q <= fl_d;
    end

    assign lt_irq = fl_q.lt_flag;
    assign rt_irq = fl_q.rt_flag;

endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
    import dpm_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 8,
    parameter bit MBOX_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lt_cs,
    input  logic              lt_we,
    input  logic              lt_oe,
    input  logic              lt_hold,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic [DATA_W-1:0] lt_wdata,
    output logic [DATA_W-1:0] lt_rdata,
    output logic              lt_rvalid,
    output logic              lt_irq,
    input  logic              rt_cs,
    input  logic              rt_we,
    input  logic              rt_oe,
    input  logic              rt_hold,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [DATA_W-1:0] rt_wdata,
    output logic [DATA_W-1:0] rt_rdata,
    output logic              rt_rvalid,
    output logic              rt_irq
);
    localparam int NPORT = 2;

    dpm_ctl_t          ctl   [NPORT];
    logic [DATA_W-1:0] word  [NPORT];
    logic [DATA_W-1:0] rdat  [NPORT];
    logic              rval  [NPORT];

    assign ctl[0] = '{cs: lt_cs, we: lt_we, oe: lt_oe, hold: lt_hold};
    assign ctl[1] = '{cs: rt_cs, we: rt_we, oe: rt_oe, hold: rt_hold};

    dpm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .a_wr    (ctl_writes(ctl[0])),
        .a_addr  (lt_addr),
        .a_wdata (lt_wdata),
        .b_wr    (ctl_writes(ctl[1])),
        .b_addr  (rt_addr),
        .b_wdata (rt_wdata),
        .a_word  (word[0]),
        .b_word  (word[1])
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        dpm_rdport #(.DATA_W(DATA_W)) u_rd (
            .clk    (clk),
            .rst    (rst),
            .rd_en  (ctl_reads(ctl[p])),
            .word   (word[p]),
            .rdata  (rdat[p]),
            .rvalid (rval[p])
        );
    end

    assign lt_rdata  = rdat[0];
    assign lt_rvalid = rval[0];
    assign rt_rdata  = rdat[1];
    assign rt_rvalid = rval[1];

    dpm_mbox #(.ADDR_W(ADDR_W), .MBOX_EN(MBOX_EN)) u_mbox (
        .clk     (clk),
        .rst     (rst),
        .lt_ctl  (ctl[0]),
        .lt_addr (lt_addr),
        .rt_ctl  (ctl[1]),
        .rt_addr (rt_addr),
        .lt_irq  (lt_irq),
        .rt_irq  (rt_irq)
    );

endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 8,
    parameter bit MBOX_EN = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              lt_cs,
    input logic              lt_we,
    input logic              lt_oe,
    input logic              lt_hold,
    input logic [ADDR_W-1:0] lt_addr,
    input logic [DATA_W-1:0] lt_rdata,
    input logic              lt_rvalid,
    input logic              lt_irq,
    input logic              rt_cs,
    input logic              rt_we,
    input logic              rt_oe,
    input logic              rt_hold,
    input logic [ADDR_W-1:0] rt_addr,
    input logic [DATA_W-1:0] rt_rdata,
    input logic              rt_rvalid,
    input logic              rt_irq
);
    localparam logic [ADDR_W-1:0] LT_BOX = {ADDR_W{1'b1}} - 1'b1;
    localparam logic [ADDR_W-1:0] RT_BOX = {ADDR_W{1'b1}};

    logic lt_post, rt_post;
    assign lt_post = rt_cs && rt_we && !rt_hold && rt_addr == LT_BOX;
    assign rt_post = lt_cs && lt_we && !lt_hold && lt_addr == RT_BOX;

    // R1: a read access yields valid data one cycle later
    a_r1_read_valid: assert property (@(posedge clk) disable iff (rst)
        (lt_cs && lt_oe) |=> lt_rvalid);

    // R2: no read access means zero and invalid
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !(rt_cs && rt_oe) |=> (!rt_rvalid && rt_rdata == '0));

    // R3: right-port mailbox write raises the left interrupt
    a_r3_lt_set: assert property (@(posedge clk) disable iff (rst)
        (MBOX_EN && lt_post) |=> lt_irq);

    // R4: left-port mailbox write raises the right interrupt
    a_r4_rt_set: assert property (@(posedge clk) disable iff (rst)
        (MBOX_EN && rt_post) |=> rt_irq);

    // R5: acknowledge read clears the flag when no set competes
    a_r5_lt_clear: assert property (@(posedge clk) disable iff (rst)
        (lt_cs && lt_oe && lt_addr == LT_BOX && !lt_post) |=> !lt_irq);

    // R6: a flag only rises after an unheld mailbox write
    a_r6_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(rt_irq) |-> $past(rt_post));

    // R10: disabled mailbox keeps both interrupts low
    a_r10_no_irq: assert property (@(posedge clk) disable iff (rst)
        !MBOX_EN |-> (!lt_irq && !rt_irq));

endmodule

bind dpram_mailbox dpm_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MBOX_EN(MBOX_EN)
) u_chk (
    .clk(clk), .rst(rst),
    .lt_cs(lt_cs), .lt_we(lt_we), .lt_oe(lt_oe), .lt_hold(lt_hold),
    .lt_addr(lt_addr), .lt_rdata(lt_rdata), .lt_rvalid(lt_rvalid), .lt_irq(lt_irq),
    .rt_cs(rt_cs), .rt_we(rt_we), .rt_oe(rt_oe), .rt_hold(rt_hold),
    .rt_addr(rt_addr), .rt_rdata(rt_rdata), .rt_rvalid(rt_rvalid), .rt_irq(rt_irq)
);

// File: tb/dpram_mailbox_tb.sv
module dpram_mailbox_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       l_cs = 0, l_we = 0, l_oe = 0, l_hold = 0;
    logic [10:0] l_addr = '0;
    logic [7:0] l_wd = '0;
    logic       r_cs = 0, r_we = 0, r_oe = 0, r_hold = 0;
    logic [10:0] r_addr = '0;
    logic [7:0] r_wd = '0;

    logic [7:0] lt_rdata, rt_rdata, nl_rdata, nr_rdata;
    logic       lt_rvalid, rt_rvalid, lt_irq, rt_irq;
    logic       nl_rvalid, nr_rvalid, nl_irq, nr_irq;

    dpram_mailbox u_dut (
        .clk(clk), .rst(rst),
        .lt_cs(l_cs), .lt_we(l_we), .lt_oe(l_oe), .lt_hold(l_hold),
        .lt_addr(l_addr), .lt_wdata(l_wd),
        .lt_rdata(lt_rdata), .lt_rvalid(lt_rvalid), .lt_irq(lt_irq),
        .rt_cs(r_cs), .rt_we(r_we), .rt_oe(r_oe), .rt_hold(r_hold),
        .rt_addr(r_addr), .rt_wdata(r_wd),
        .rt_rdata(rt_rdata), .rt_rvalid(rt_rvalid), .rt_irq(rt_irq)
    );

    dpram_mailbox #(.MBOX_EN(1'b0)) u_dut_nobox (
        .clk(clk), .rst(rst),
        .lt_cs(l_cs), .lt_we(l_we), .lt_oe(l_oe), .lt_hold(l_hold),
        .lt_addr(l_addr), .lt_wdata(l_wd),
        .lt_rdata(nl_rdata), .lt_rvalid(nl_rvalid), .lt_irq(nl_irq),
        .rt_cs(r_cs), .rt_we(r_we), .rt_oe(r_oe), .rt_hold(r_hold),
        .rt_addr(r_addr), .rt_wdata(r_wd),
        .rt_rdata(nr_rdata), .rt_rvalid(nr_rvalid), .rt_irq(nr_irq)
    );

    // Behavioural reference model
    logic [7:0] ref_mem [0:2047];
    logic       e_lv = 0, e_rv = 0, e_li = 0, e_ri = 0;
    logic [7:0] e_ld = 0, e_rd = 0;
    bit         started = 0;
    bit         done = 0;
    string      tag = "R11";
    int         n_chk = 0, n_fail = 0;

    always @(posedge clk) begin
        if (rst) begin
            e_lv <= 0; e_rv <= 0; e_ld <= 0; e_rd <= 0; e_li <= 0; e_ri <= 0;
        end else begin
            automatic bit lw = l_cs && l_we && !l_hold;
            automatic bit rw = r_cs && r_we && !r_hold;
            automatic bit lr = l_cs && l_oe;
            automatic bit rr = r_cs && r_oe;
            automatic bit ls = rw && r_addr == 11'h7FE;
            automatic bit rs = lw && l_addr == 11'h7FF;
            e_lv <= lr; e_ld <= lr ? ref_mem[l_addr] : 8'h00;
            e_rv <= rr; e_rd <= rr ? ref_mem[r_addr] : 8'h00;
            if (ls) e_li <= 1; else if (lr && l_addr == 11'h7FE) e_li <= 0;
            if (rs) e_ri <= 1; else if (rr && r_addr == 11'h7FF) e_ri <= 0;
            if (rw) ref_mem[r_addr] = r_wd;
            if (lw) ref_mem[l_addr] = l_wd;
        end
        started <= 1;
    end

    task automatic chk(input string t, input string what, input bit ok,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", t, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (started && !done) begin
        chk(tag, "lt_rvalid", lt_rvalid == e_lv, {7'b0, lt_rvalid}, {7'b0, e_lv});
        chk(tag, "lt_rdata",  lt_rdata  == e_ld, lt_rdata, e_ld);
        chk(tag, "rt_rvalid", rt_rvalid == e_rv, {7'b0, rt_rvalid}, {7'b0, e_rv});
        chk(tag, "rt_rdata",  rt_rdata  == e_rd, rt_rdata, e_rd);
        chk(tag, "lt_irq",    lt_irq == e_li, {7'b0, lt_irq}, {7'b0, e_li});
        chk(tag, "rt_irq",    rt_irq == e_ri, {7'b0, rt_irq}, {7'b0, e_ri});
        chk("R10", "nobox irq", !nl_irq && !nr_irq, {6'b0, nl_irq, nr_irq}, 8'h00);
        chk("R10", "nobox lt_rdata", nl_rdata == e_ld && nl_rvalid == e_lv, nl_rdata, e_ld);
        chk("R10", "nobox rt_rdata", nr_rdata == e_rd && nr_rvalid == e_rv, nr_rdata, e_rd);
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drv_l(input bit cs, we, oe, hold, input logic [10:0] a, input logic [7:0] d);
        l_cs = cs; l_we = we; l_oe = oe; l_hold = hold; l_addr = a; l_wd = d;
    endtask

    task automatic drv_r(input bit cs, we, oe, hold, input logic [10:0] a, input logic [7:0] d);
        r_cs = cs; r_we = we; r_oe = oe; r_hold = hold; r_addr = a; r_wd = d;
    endtask

    task automatic idle();
        drv_l(0, 0, 0, 0, '0, '0);
        drv_r(0, 0, 0, 0, '0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        tag = "R11";
        idle();
        repeat (3) step();
        rst = 0;
        step();

        // R1: fill a set of locations from both ports
        tag = "R1";
        for (int i = 0; i < 8; i++) begin
            drv_l(1, 1, 0, 0, 11'(i), 8'(8'h10 + i));
            drv_r(1, 1, 0, 0, 11'(i + 1024), 8'(8'hA0 + i));
            step();
        end
        idle();
        for (int i = 0; i < 8; i++) begin
            drv_l(1, 0, 1, 0, 11'(i + 1024), 8'h00);
            drv_r(1, 0, 1, 0, 11'(i), 8'h00);
            step();
        end

        // R2: deselected or read disabled gives zero
        tag = "R2";
        drv_l(1, 0, 0, 0, 11'd2, 8'h00);
        drv_r(0, 0, 1, 0, 11'd3, 8'h00);
        step();
        idle(); step();

        // R3 and R7: right posts to the left mailbox
        tag = "R3";
        drv_r(1, 1, 0, 0, 11'h7FE, 8'h5A); step();
        idle(); step(); step();
        tag = "R7";
        drv_r(1, 0, 1, 0, 11'h7FE, 8'h00); step();   // right reads, no clear
        idle(); step();
        // R5: left acknowledges with we high, data still read
        tag = "R5";
        drv_l(1, 1, 1, 0, 11'h7FE, 8'h77); step();
        idle(); step();
        // R4: left posts to the right mailbox
        tag = "R4";
        drv_l(1, 1, 0, 0, 11'h7FF, 8'hC3); step();
        idle(); step();
        tag = "R5";
        drv_r(1, 0, 1, 0, 11'h7FF, 8'h00); step();
        idle(); step();
        // R5: set and clear together, set wins
        drv_r(1, 1, 0, 0, 11'h7FE, 8'h11); step();
        drv_r(1, 1, 0, 0, 11'h7FE, 8'h22);
        drv_l(1, 0, 1, 0, 11'h7FE, 8'h00); step();
        idle(); step();
        drv_l(1, 0, 1, 0, 11'h7FE, 8'h00); step();
        idle(); step();

        // R6: hold blocks data and mailbox set
        tag = "R6";
        drv_r(1, 1, 0, 1, 11'h7FE, 8'hEE);
        drv_l(1, 1, 0, 1, 11'd5, 8'hEE); step();
        idle(); step();
        drv_l(1, 0, 1, 0, 11'd5, 8'h00);
        drv_r(1, 0, 1, 0, 11'h7FE, 8'h00); step();
        idle(); step();

        // R8: same-address double write
        tag = "R8";
        drv_l(1, 1, 0, 0, 11'd6, 8'h3C);
        drv_r(1, 1, 0, 0, 11'd6, 8'hC3); step();
        drv_l(1, 0, 1, 0, 11'd6, 8'h00); idle(); drv_l(1, 0, 1, 0, 11'd6, 8'h00); step();
        idle(); step();

        // R9: read during write returns old contents
        tag = "R9";
        drv_l(1, 1, 1, 0, 11'd3, 8'h99);
        drv_r(1, 0, 1, 0, 11'd3, 8'h00); step();
        drv_r(1, 0, 1, 0, 11'd3, 8'h00); drv_l(0, 0, 0, 0, '0, '0); step();
        idle(); step();

        // R11: reset with a pending flag, memory survives
        tag = "R11";
        drv_l(1, 1, 0, 0, 11'h7FF, 8'h42); step();
        idle(); rst = 1; step(); step();
        rst = 0; step();
        drv_l(1, 0, 1, 0, 11'h7FF, 8'h00); step();
        idle(); step();

        // R1: random mix over known locations
        tag = "R1";
        for (int n = 0; n < 3000; n++) begin
            automatic logic [10:0] la, ra;
            la = ($urandom % 5 == 0) ? 11'(11'h7FE + $urandom % 2) : 11'($urandom % 8);
            ra = ($urandom % 5 == 0) ? 11'(11'h7FE + $urandom % 2) : 11'($urandom % 8);
            drv_l($urandom % 4 != 0, $urandom % 3 == 0, $urandom % 2 == 0,
                  $urandom % 6 == 0, la, 8'($urandom));
            drv_r($urandom % 4 != 0, $urandom % 3 == 0, $urandom % 2 == 0,
                  $urandom % 6 == 0, ra, 8'($urandom));
            step();
        end
        idle(); step(); step();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule